// File: doc/BRIEF.md
# Snoop-Gated Inbound Access Filter

This block sits between the target side of an external bus interface and the local memory port. Every access that an outside bus master starts is checked against two programmable address windows. When snooping is enabled and the address falls in either window, the access is held back. The block first asks the CPU cache to write back the line (reads) or to invalidate it (writes). The memory request is issued only after the cache acknowledges. Accesses that miss both windows, and all accesses while snooping is disabled, go straight to memory with no extra cycle.

The host-bridge and normal roles of the bus interface are treated the same way, so the filter has no input for them. If a window hit arrives while the CPU is asleep, the cache cannot answer. The access then completes at once with an error, nothing reaches memory, and a sticky status bit records the event. A configuration error output flags the unsupported case of prefetching being enabled together with snooping. The front end is expected to hold its request, address and direction stable until it sees a grant or an error.

Top module: `tgt_snoop_filter`

## Requirements
- R1: After reset every register reads zero, snooping is disabled, and `memReq`, `snpReq`, `inErr` and `cfgErr` are low.
- R2: Window n (n = 0, 1) matches when `(inAddr & mask_n) == (base_n & mask_n)`. An access is a hit when either window matches.
- R3: While the mode register is zero, every access passes straight through in the same cycle (`memReq` = `inReq`, `inGnt` = `memGnt`) and no cache request is made, even inside a window.
- R4: With snooping enabled, an access that misses both windows is forwarded in the same cycle with no cache request.
- R5: On a hit with sleep low, `memReq` stays low and `snpReq` rises on the cycle after the access is presented.
- R6: `snpPurge` is 1 (invalidate) for a write hit and 0 (write back) for a read hit, and it is stable while `snpReq` is high.
- R7: `snpReq` stays high until `snpAck` is sampled. The memory request is issued on the next cycle, so a hit completes 2 + d cycles after it is presented, where d is the number of cycles the acknowledge is delayed.
- R8: On a hit while `sleepIn` is high, `inErr` is raised in the same cycle, and neither `memReq` nor `snpReq` is asserted for that access.
- R9: The status register (index 5) bit 0 is set by a sleep-time hit. It is cleared only by writing 1 to that bit, and writing 0 leaves it set.
- R10: `cfgErr` is high exactly when `prefetchEn` is high and the mode register is nonzero.
- R11: Register indices are: base0 = 0, mask0 = 1, base1 = 2, mask1 = 3, mode = 4 (bits 1:0, nonzero enables snooping), status = 5. Writes to each are read back on `regRdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWdata | input | AW | Register write data |
| regRdata | output | AW | Register read data for `regAddr` |
| inReq | input | 1 | Inbound access request from the bus front end |
| inWe | input | 1 | Inbound access is a write |
| inAddr | input | AW | Inbound access address |
| inGnt | output | 1 | Inbound access completed normally |
| inErr | output | 1 | Inbound access completed with an error |
| memReq | output | 1 | Memory port request |
| memWe | output | 1 | Memory port write flag |
| memAddr | output | AW | Memory port address |
| memGnt | input | 1 | Memory port grant |
| snpReq | output | 1 | Cache write-back/invalidate request |
| snpPurge | output | 1 | 1 = invalidate, 0 = write back |
| snpAddr | output | AW | Address of the line to process |
| snpAck | input | 1 | Cache acknowledge |
| sleepIn | input | 1 | CPU is in the sleep state |
| prefetchEn | input | 1 | Prefetch function enabled |
| cfgErr | output | 1 | Prefetch and snooping are both on |

## Verification
The bench builds the filter with the default 32-bit address. This lets the windows use masks that compare only the top nibble or the top half-word, so accesses that differ only below the mask boundary land on both sides of a window edge. It varies the cache acknowledge delay between hits, which makes the 2 + d completion latency observable at several values. It also replays sleep-time hits to exercise the error path and the write-one-to-clear behaviour.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int NWIN     = 2;
  localparam int REG_AW   = 3;
  localparam logic [REG_AW-1:0] REG_MODE = REG_AW'(2 * NWIN);
  localparam logic [REG_AW-1:0] REG_STAT = REG_AW'(2 * NWIN + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SNOOP,
    ST_RELEASE
  } snpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setErr;
    logic latchPurge;
  } ctrlStrobe_t;
endpackage

// File: rtl/snoop_dp.sv
module snoop_dp
  import snoop_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [AW-1:0]     regWdata,
  output logic [AW-1:0]     regRdata,
  input  logic [AW-1:0]     inAddr,
  input  logic              inWe,
  input  ctrlStrobe_t       strobe,
  output logic              hit,
  output logic              snoopOn,
  output logic              purge
);
  logic [AW-1:0] baseQ [NWIN];
  logic [AW-1:0] maskQ [NWIN];
  logic [1:0]    modeQ;
  logic          errQ;
  logic          purgeQ;
  logic [NWIN-1:0] winMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NWIN; w++) begin
        baseQ[w] <= '0;
        maskQ[w] <= '0;
      end
      modeQ  <= '0;
      errQ   <= 1'b0;
      purgeQ <= 1'b0;
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (regWe && regAddr == REG_AW'(2 * w))     baseQ[w] <= regWdata;
        if (regWe && regAddr == REG_AW'(2 * w + 1)) maskQ[w] <= regWdata;
      end
      if (regWe && regAddr == REG_MODE) modeQ <= regWdata[1:0];
      if (strobe.setErr) errQ <= 1'b1;
      else if (regWe && regAddr == REG_STAT && regWdata[0]) errQ <= 1'b0;
      if (strobe.latchPurge) purgeQ <= inWe;
    end
  end

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign winMatch[w] = ((inAddr ^ baseQ[w]) & maskQ[w]) == '0;
    end
  endgenerate

  assign snoopOn = modeQ != 2'b00;
  assign hit     = snoopOn && (|winMatch);
  assign purge   = purgeQ;

  always_comb begin
    regRdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (regAddr == REG_AW'(2 * w))     regRdata = baseQ[w];
      if (regAddr == REG_AW'(2 * w + 1)) regRdata = maskQ[w];
    end
    if (regAddr == REG_MODE) regRdata[1:0] = modeQ;
    if (regAddr == REG_STAT) regRdata[0]   = errQ;
  end

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setErr |=> errQ);
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inReq,
  input  logic        hit,
  input  logic        sleepIn,
  input  logic        snpAck,
  input  logic        memGnt,
  output logic        memReq,
  output logic        inGnt,
  output logic        inErr,
  output logic        snpReq,
  output ctrlStrobe_t strobe
);
  snpState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    memReq = 1'b0;
    inGnt  = 1'b0;
    inErr  = 1'b0;
    snpReq = 1'b0;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (inReq) begin
          if (!hit) begin
            memReq = 1'b1;
            inGnt  = memGnt;
          end else if (sleepIn) begin
            inErr         = 1'b1;
            strobe.setErr = 1'b1;
          end else begin
            strobe.latchPurge = 1'b1;
            stateD            = ST_SNOOP;
          end
        end
      end
      ST_SNOOP: begin
        snpReq = 1'b1;
        if (snpAck) stateD = ST_RELEASE;
      end
      ST_RELEASE: begin
        memReq = inReq;
        inGnt  = inReq && memGnt;
        if (!inReq || memGnt) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R7
  snoop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpReq && !snpAck |=> snpReq);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpReq && snpAck && inReq |=> memReq);
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    inErr |-> !memReq && !snpReq);
  // R5
  snp_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(snpReq) |-> $past(inReq && hit && !sleepIn));
endmodule

// File: rtl/tgt_snoop_filter.sv
module tgt_snoop_filter
  import snoop_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [AW-1:0]     regWdata,
  output logic [AW-1:0]     regRdata,
  input  logic              inReq,
  input  logic              inWe,
  input  logic [AW-1:0]     inAddr,
  output logic              inGnt,
  output logic              inErr,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  input  logic              memGnt,
  output logic              snpReq,
  output logic              snpPurge,
  output logic [AW-1:0]     snpAddr,
  input  logic              snpAck,
  input  logic              sleepIn,
  input  logic              prefetchEn,
  output logic              cfgErr
);
  ctrlStrobe_t strobe;
  logic        hit;
  logic        snoopOn;

  snoop_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inAddr(inAddr), .inWe(inWe),
    .strobe(strobe), .hit(hit), .snoopOn(snoopOn), .purge(snpPurge)
  );

  snoop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inReq(inReq), .hit(hit), .sleepIn(sleepIn),
    .snpAck(snpAck), .memGnt(memGnt), .memReq(memReq), .inGnt(inGnt),
    .inErr(inErr), .snpReq(snpReq), .strobe(strobe)
  );

  assign memWe   = inWe;
  assign memAddr = inAddr;
  assign snpAddr = inAddr;
  assign cfgErr  = prefetchEn && snoopOn;

  // R6
  purge_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpReq && $past(snpReq) |-> $stable(snpPurge));
endmodule

// File: tb/tgt_snoop_filter_tb.sv
`timescale 1ns/1ps
module tgt_snoop_filter_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [AW-1:0] regWdata = '0;
  logic [AW-1:0] regRdata;
  logic inReq = 1'b0, inWe = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic inGnt, inErr, memReq, memWe, memGnt, snpReq, snpPurge, cfgErr;
  logic [AW-1:0] memAddr, snpAddr;
  logic snpAck = 1'b0, sleepIn = 1'b0, prefetchEn = 1'b0;

  assign memGnt = memReq;

  tgt_snoop_filter #(.AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inReq(inReq), .inWe(inWe),
    .inAddr(inAddr), .inGnt(inGnt), .inErr(inErr), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memGnt(memGnt), .snpReq(snpReq),
    .snpPurge(snpPurge), .snpAddr(snpAddr), .snpAck(snpAck),
    .sleepIn(sleepIn), .prefetchEn(prefetchEn), .cfgErr(cfgErr)
  );

  typedef struct {
    bit isErr;
    bit we;
    logic [AW-1:0] addr;
    bit snooped;
    int lat;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int nChk = 0, nFail = 0;
  int cyc = 0;
  int startCyc = 0;
  int ackDly = 0, ackCnt = 0;
  bit sawSnp = 0, done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // cache model
  always @(negedge clk) begin
    if (snpReq) begin
      sawSnp = 1;
      chk("R6 purge type", snpPurge, inWe);
      chk("R5 no mem during snoop", memReq, 1'b0);
      if (ackCnt == ackDly) snpAck = 1'b1;
      else begin ackCnt++; snpAck = 1'b0; end
    end else begin
      snpAck = 1'b0;
      ackCnt = 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rstN && (inErr || (memReq && memGnt))) begin
      if (expQ.size() == 0) chk("unexpected completion", 1, 0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        chk({e.tag, " error flag"}, inErr, e.isErr);
        if (!e.isErr) begin
          chk({e.tag, " grant"}, inGnt, 1'b1);
          chk({e.tag, " addr"}, memAddr, e.addr);
          chk({e.tag, " dir"}, memWe, e.we);
        end
        chk({e.tag, " snooped"}, sawSnp, e.snooped);
        chk({e.tag, " latency"}, cyc - startCyc, e.lat);
      end
      done = 1;
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] addr, input bit isErr,
                        input bit snooped, input int dly, input string tag);
    exp_t e;
    e.isErr = isErr; e.we = we; e.addr = addr; e.snooped = snooped;
    e.lat = snooped ? 2 + dly : 0; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk); #1;
    ackDly = dly; sawSnp = 0; done = 0;
    inReq = 1'b1; inWe = we; inAddr = addr; startCyc = cyc;
    wait (done);
    @(posedge clk); #1;
    inReq = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [AW-1:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic regCheck(input logic [2:0] a, input logic [AW-1:0] exp, input string tag);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    chk(tag, regRdata, exp);
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 memReq", memReq, 0);
    chk("R1 snpReq", snpReq, 0);
    chk("R1 inErr", inErr, 0);
    chk("R1 cfgErr", cfgErr, 0);
    for (int i = 0; i < 6; i++) regCheck(3'(i), '0, "R1 reg zero");

    regWrite(3'd0, 32'h1000_0000);
    regWrite(3'd1, 32'hF000_0000);
    regWrite(3'd2, 32'h8000_0000);
    regWrite(3'd3, 32'hFFFF_0000);
    // mode still zero: R3 passthrough even in a window
    access(1, 32'h1000_0040, 0, 0, 0, "R3 disabled write");
    access(0, 32'h8000_0004, 0, 0, 0, "R3 disabled read");

    regWrite(3'd4, 32'h1);
    regCheck(3'd0, 32'h1000_0000, "R11 base0");
    regCheck(3'd1, 32'hF000_0000, "R11 mask0");
    regCheck(3'd2, 32'h8000_0000, "R11 base1");
    regCheck(3'd3, 32'hFFFF_0000, "R11 mask1");
    regCheck(3'd4, 32'h1, "R11 mode");

    access(0, 32'h2000_0000, 0, 0, 0, "R4 miss read");
    access(1, 32'h8001_0000, 0, 0, 0, "R4 miss edge of window1");
    access(1, 32'h1FFF_FFF0, 0, 1, 0, "R2 R6 R7 window0 write hit");
    access(0, 32'h1000_0100, 0, 1, 3, "R6 R7 window0 read hit delayed");
    access(0, 32'h8000_1234, 0, 1, 1, "R2 window1 read hit");
    access(1, 32'h8000_FFFC, 0, 1, 5, "R5 R7 window1 write hit");

    sleepIn = 1'b1;
    access(0, 32'h1000_0008, 1, 0, 0, "R8 sleep hit");
    access(1, 32'h3000_0000, 0, 0, 0, "R8 sleep miss passes");
    regCheck(3'd5, 32'h1, "R9 sticky set");
    regWrite(3'd5, 32'h0);
    regCheck(3'd5, 32'h1, "R9 write zero keeps");
    regWrite(3'd5, 32'h1);
    regCheck(3'd5, 32'h0, "R9 w1c clears");
    sleepIn = 1'b0;

    prefetchEn = 1'b1;
    @(negedge clk); chk("R10 cfgErr on", cfgErr, 1);
    regWrite(3'd4, 32'h0);
    @(negedge clk); chk("R10 cfgErr mode0", cfgErr, 0);
    prefetchEn = 1'b0;
    regWrite(3'd4, 32'h2);
    @(negedge clk); chk("R10 cfgErr no prefetch", cfgErr, 0);
    access(0, 32'h1234_5678, 0, 1, 2, "R2 mode 2 enables");

    repeat (2) @(posedge clk);
    chk("scoreboard drained", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule